// File: doc/BRIEF.md
# Software Watchdog Reset Timer

This block catches a program that has stopped running its normal sequence. A prescaler divides the CPU clock by a fixed ratio. On each prescaler tick a 7-bit counter steps down by one. Software must reload the counter through a simple write port before bit 6 of the counter drops to zero. If the watchdog is enabled and that bit falls from 1 to 0, the block pulls an active-low reset output down for a fixed number of CPU cycles. The pulse ends, and the block itself returns to its reset state, as the rest of the chip would.

The enable can reach the active state in two ways. Software can set it through bit 7 of the write word, and once set it stays set until the next reset. A tie-off input can also hold it on from reset. A second tie-off input turns a HALT request into an immediate reset whenever the watchdog is active. A read returns the enable state in bit 7 and the counter in bits 6:0.

Top module: `wdog_timer`

## Requirements
- R1: After reset the read port shows counter 0x7F, bit 7 equal to `opt_hw_en`, and `wdg_rst_n` is high.
- R2: With no write, the counter steps down by exactly one every `PRESCALE` clocks, and it wraps from 0x00 to 0x7F.
- R3: A write loads `wr_data[6:0]` into the counter and restarts the prescaler, so the first decrement after a write comes exactly `PRESCALE` clocks after it. A write and a tick in the same cycle resolve in favour of the write.
- R4: A write with `wr_data[7]`=1 enables the watchdog. A write with `wr_data[7]`=0 never disables it. Read bit 7 shows the enable state.
- R5: While the watchdog is enabled, the tick that would move the counter from 0x40 to 0x3F instead drives `wdg_rst_n` low, starting at that same clock edge.
- R6: While the watchdog is disabled, the 0x40 to 0x3F step happens normally and `wdg_rst_n` stays high.
- R7: Every reset pulse keeps `wdg_rst_n` low for exactly `PULSE_CYCLES` clocks. After the pulse, the read port shows the R1 reset values.
- R8: A write whose `wr_data[6]` is 0 starts a reset pulse at that edge if the watchdog is enabled before the write or is enabled by the write. Otherwise the write only loads the counter.
- R9: With `opt_hw_en`=1 the watchdog is active from reset, read bit 7 is 1, and counter expiry resets the system with no software write.
- R10: A `halt_req` pulse starts a reset pulse only when `opt_halt_rst`=1 and the watchdog is enabled. In every other case it has no effect.
- R11: During a reset pulse, writes and HALT requests are ignored, and the read port shows counter 0x7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low system reset |
| opt_hw_en | input | 1 | Tie-off: watchdog forced active |
| opt_halt_rst | input | 1 | Tie-off: HALT request causes reset while active |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write word: bit 7 enable, bits 6:0 counter |
| halt_req | input | 1 | HALT request from the core |
| rd_data | output | 8 | Read word: bit 7 enable state, bits 6:0 counter |
| wdg_rst_n | output | 1 | Active-low reset pulse |

## Verification
The assertions check the following on every cycle:
- the counter moves only by single downward steps when no write occurs;
- a write loads the written count;
- the enable never falls outside a reset pulse;
- each pulse has the exact width;
- the read port holds its reset values during a pulse;
- any enabled HALT request with the option set produces a pulse.

Other behaviours can only be shown by the bench's scenarios, which it checks against a behavioural reference model on every clock:
- the exact cycle of the prescaler tick after a write;
- the wrap from 0x00;
- expiry with and without the enable;
- a write that clears bit 6 both before and after enabling;
- the two option modes.

// File: rtl/wdog_timer.sv
`timescale 1ns/1ps
module wdog_timer #(
  parameter int PRESCALE     = 16000,
  parameter int PULSE_CYCLES = 240
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       opt_hw_en,
  input  logic       opt_halt_rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       halt_req,
  output logic [7:0] rd_data,
  output logic       wdg_rst_n
);
  localparam int PW = $clog2(PRESCALE);
  localparam int LW = $clog2(PULSE_CYCLES + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);
  localparam logic [LW-1:0] PLS_LEN  = LW'(PULSE_CYCLES);
  localparam logic [6:0]    CNT_INIT = 7'h7F;
  localparam logic [6:0]    CNT_EDGE = 7'h40;

  logic [PW-1:0] pre_q;
  logic [6:0]    cnt_q;
  logic          en_q;
  logic [LW-1:0] pls_q;

  wire pulsing   = pls_q != '0;
  wire tick      = pre_q == PRE_LAST;
  wire active    = en_q | opt_hw_en;
  wire fire_wr   = wr_en & (active | wr_data[7]) & ~wr_data[6];
  wire fire_exp  = ~wr_en & active & tick & (cnt_q == CNT_EDGE);
  wire fire_halt = halt_req & opt_halt_rst & active;
  wire fire      = ~pulsing & (fire_wr | fire_exp | fire_halt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= CNT_INIT;
      en_q  <= 1'b0;
      pls_q <= '0;
    end else if (pulsing) begin
      pls_q <= pls_q - 1'b1;
    end else if (fire) begin
      pls_q <= PLS_LEN;
      pre_q <= '0;
      cnt_q <= CNT_INIT;
      en_q  <= 1'b0;
    end else if (wr_en) begin
      pre_q <= '0;
      cnt_q <= wr_data[6:0];
      en_q  <= en_q | wr_data[7];
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign rd_data   = {active, cnt_q};
  assign wdg_rst_n = ~pulsing;
endmodule

// File: rtl/wdog_timer_chk.sv
`timescale 1ns/1ps
module wdog_timer_chk #(
  parameter int PULSE_CYCLES = 240
) (
  input logic       clk,
  input logic       rst_n,
  input logic       opt_hw_en,
  input logic       opt_halt_rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       halt_req,
  input logic [7:0] rd_data,
  input logic       wdg_rst_n
);
  int unsigned low_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_n <= 0;
    else if (!wdg_rst_n) low_n <= low_n + 1;
    else                 low_n <= 0;
  end

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wdg_rst_n && $past(wdg_rst_n) && !$past(wr_en) && rd_data[6:0] != $past(rd_data[6:0]))
      |-> rd_data[6:0] == $past(rd_data[6:0]) - 7'd1);

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wdg_rst_n && wr_en && wr_data[6] && !(halt_req && opt_halt_rst))
      |=> rd_data[6:0] == $past(wr_data[6:0]));

  p_enable_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wdg_rst_n && wr_en && wr_data[6] && !(halt_req && opt_halt_rst))
      |=> rd_data[7] == ($past(rd_data[7]) | $past(wr_data[7])));

  p_enable_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_data[7]) && wdg_rst_n) |-> rd_data[7]);

  p_pulse_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wdg_rst_n |-> low_n < PULSE_CYCLES);

  p_pulse_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdg_rst_n) |-> $past(low_n) == PULSE_CYCLES - 1);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wdg_rst_n |-> rd_data == {opt_hw_en, 7'h7F});

  p_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && opt_halt_rst && rd_data[7] && wdg_rst_n) |=> !wdg_rst_n);
endmodule

bind wdog_timer wdog_timer_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (.*);

// File: tb/test_wdog_timer.sv
`timescale 1ns/1ps
module test_wdog_timer;
  localparam int PRE = 8;
  localparam int PLS = 5;

  logic clk = 0, rst_n = 0, opt_hw_en = 0, opt_halt_rst = 0;
  logic wr_en = 0, halt_req = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic wdg_rst_n;

  int checks = 0, failures = 0;
  int m_pre, m_cnt, m_en, m_pls;
  bit done = 0;

  always #10 clk = ~clk;

  wdog_timer #(.PRESCALE(PRE), .PULSE_CYCLES(PLS)) i_wdog_timer (
    .clk(clk), .rst_n(rst_n), .opt_hw_en(opt_hw_en), .opt_halt_rst(opt_halt_rst),
    .wr_en(wr_en), .wr_data(wr_data), .halt_req(halt_req),
    .rd_data(rd_data), .wdg_rst_n(wdg_rst_n));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  always @(posedge clk) begin
    bit act, boom;
    if (!rst_n) begin
      m_pre = 0; m_cnt = 127; m_en = 0; m_pls = 0;
    end else if (m_pls > 0) begin
      m_pls--;
    end else begin
      act = (m_en != 0) || opt_hw_en;
      boom = halt_req && opt_halt_rst && act;
      if (wr_en) begin
        if ((act || wr_data[7]) && !wr_data[6]) boom = 1;
      end else if (m_pre == PRE - 1 && act && m_cnt == 64) boom = 1;
      if (boom) begin
        m_pls = PLS; m_pre = 0; m_cnt = 127; m_en = 0;
      end else if (wr_en) begin
        m_cnt = wr_data[6:0]; m_pre = 0;
        if (wr_data[7]) m_en = 1;
      end else begin
        m_pre++;
        if (m_pre == PRE) begin
          m_pre = 0;
          m_cnt = (m_cnt + 127) % 128;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 model read", rd_data, ((m_en != 0 || opt_hw_en) ? 128 : 0) + m_cnt);
      check("R5 model reset out", wdg_rst_n, m_pls == 0);
    end
  end

  task automatic do_reset(bit hw, bit hr);
    @(posedge clk); #2;
    rst_n = 0; opt_hw_en = hw; opt_halt_rst = hr;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
  endtask

  task automatic wr(logic [7:0] d);
    @(posedge clk); #2 wr_en = 1; wr_data = d;
    @(posedge clk); #2 wr_en = 0;
  endtask

  task automatic halt_pulse();
    @(posedge clk); #2 halt_req = 1;
    @(posedge clk); #2 halt_req = 0;
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wait_high();
    while (!wdg_rst_n) @(negedge clk);
  endtask

  task automatic finish_up();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #3_000_000;
    failures++;
    $display("FAIL watchdog expired R1 actual=hang expected=done");
    finish_up();
  end

  initial begin
    int len;
    do_reset(0, 0);
    @(negedge clk);
    check("R1 read", rd_data, 8'h7F);
    check("R1 out", wdg_rst_n, 1);

    wr(8'h30); @(negedge clk);
    check("R8 no fire inactive", wdg_rst_n, 1);
    check("R3 load", rd_data, 8'h30);
    edges(PRE - 1); @(negedge clk);
    check("R3 before tick", rd_data, 8'h30);
    edges(1); @(negedge clk);
    check("R3 first tick", rd_data, 8'h2F);

    wr(8'h01); edges(2 * PRE); @(negedge clk);
    check("R2 wrap", rd_data, 8'h7F);

    wr(8'h41); edges(2 * PRE); @(negedge clk);
    check("R6 inactive roll", rd_data, 8'h3F);
    check("R6 out", wdg_rst_n, 1);

    wr(8'hC5); @(negedge clk);
    check("R4 enable", rd_data, 8'hC5);
    wr(8'h52); @(negedge clk);
    check("R4 sticky", rd_data, 8'hD2);

    wr(8'hC1); edges(PRE); @(negedge clk);
    check("R5 at 0x40", rd_data, 8'hC0);
    check("R5 still high", wdg_rst_n, 1);
    edges(PRE); @(negedge clk);
    check("R5 expiry", wdg_rst_n, 0);
    len = 0;
    while (!wdg_rst_n) begin len++; @(negedge clk); end
    check("R7 pulse length", len, PLS);
    check("R7 after pulse", rd_data, 8'h7F);

    wr(8'hFF);
    wr(8'h20); @(negedge clk);
    check("R8 immediate", wdg_rst_n, 0);
    wr(8'hFF);
    halt_pulse();
    wait_high();
    check("R11 ignored during pulse", rd_data, 8'h7F);

    do_reset(0, 1);
    halt_pulse(); @(negedge clk);
    check("R10 halt inactive", wdg_rst_n, 1);
    wr(8'hFF);
    halt_pulse(); @(negedge clk);
    check("R10 halt active", wdg_rst_n, 0);
    wait_high();

    do_reset(0, 0);
    wr(8'hFF);
    halt_pulse(); @(negedge clk);
    check("R10 halt option off", wdg_rst_n, 1);

    do_reset(1, 0);
    @(negedge clk);
    check("R9 hw read", rd_data, 8'hFF);
    wr(8'h41); @(negedge clk);
    check("R9 hw stays on", rd_data, 8'hC1);
    edges(2 * PRE); @(negedge clk);
    check("R9 hw expiry", wdg_rst_n, 0);
    wait_high();
    check("R9 after pulse", rd_data, 8'hFF);
    edges(4);
    finish_up();
  end
endmodule